// File: doc/BRIEF.md
# Interpolate-by-Two FIR Sample Store

This block is the sample-storage front end of an eight-tap symmetric FIR filter that raises the sample rate by two. The plain approach inserts a zero after every input sample and pushes the padded stream through a delay line with symmetric pre-adders. This block avoids both. It keeps only real samples, one register per data bit. It permutes the register on every clock so that one member of each symmetric tap pair sits in a fixed slot. The other member of that pair would have been a stuffed zero, so no pre-adder is needed.

A phase flip-flop toggles on every advance. In the load phase a new sample enters slot 1 and the inner neighbour pairs exchange contents. In the swap phase, which follows every load, the outer neighbour pairs exchange contents. The four odd slots then form a signed dot product with four fixed coefficients, which is registered. The result is one filtered output per clock while the input supplies one sample every second clock.

The input is a valid/ready stream. `in_ready` is high exactly in the load phase, and a sample is taken when `in_valid` and `in_ready` are both high. If no sample is offered during the load phase, the block stalls: state holds and no output is produced. The output has no back-pressure, so the consumer must take every beat on which `out_valid` is high.

Top module: `up2_interp_fir`

## Requirements
- R1: After reset, all eight slots read 0, `in_ready` is 1, `out_valid` is 0 and `out_data` is 0.
- R2: `in_ready` is 1 in the load phase and 0 in the swap phase. The clock after an accepted sample is always a swap phase, and the clock after a swap phase is always a load phase.
- R3: In the load phase with `in_valid` low, the slots and phase do not change, `out_valid` is 0 on the next clock, and `out_data` keeps its value.
- R4: With n the index of the newest accepted sample (x(i) = 0 for i <= 0), the slots after an accepted sample hold, from slot 1 to slot 8: x(n), x(n-7), x(n-1), x(n-6), x(n-2), x(n-5), x(n-3), x(n-4).
- R5: After a swap phase, slots 1 to 8 hold x(n-7), x(n), x(n-6), x(n-1), x(n-5), x(n-2), x(n-4), x(n-3).
- R6: After every advance (an accepted sample or a swap phase), `out_valid` is 1 on the next clock. `out_data` then equals h1*slot1 + h2*slot3 + h3*slot5 + h4*slot7, computed in full signed precision over the new slot contents. Slot k is `tap_slots[8k-1:8k-8]`, and the coefficients h1..h4 are the signed bytes of `COEFS` from the least significant byte upward.
- R7: `in_valid` during a swap phase is ignored: the offered sample does not enter any slot, and the slots follow R5.
- R8: With `in_valid` held high, `out_valid` is high on every clock, giving two outputs per accepted input.
- R9: Samples and coefficients at the signed extremes (-128 and 127) give the exact signed result without wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Load phase, a sample can be taken |
| in_data | input | DATA_W (8) | Signed input sample |
| tap_slots | output | NPAIR*2*DATA_W (64) | Slot contents, slot 1 in the low byte |
| out_valid | output | 1 | Output sample present |
| out_data | output | OUT_W (18) | Signed filtered output |

## Verification
The assertions assume that reset is applied before the first clock and that `in_data` carries defined values whenever `in_valid` is high in the load phase. The stimulus drives known data on every clock, including during swap phases and idle cycles. Random traffic mixes stalls in the load phase with samples offered during swap phases, so the hold and ignore rules are exercised alongside the permutation sequence. Directed runs cover an unbroken stream and the signed extreme values.

// File: rtl/up2_pkg.sv
package up2_pkg;
  typedef enum logic {
    PH_LOAD = 1'b0,
    PH_SWAP = 1'b1
  } up2_phase_e;
endpackage

// File: rtl/up2_phase_ctrl.sv
module up2_phase_ctrl
  import up2_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic load_o,
  output logic swap_o
);
  up2_phase_e phase_q, phase_d;

  assign in_ready = (phase_q == PH_LOAD);
  assign load_o   = in_ready && in_valid;
  assign swap_o   = (phase_q == PH_SWAP);

  always_comb begin
    phase_d = phase_q;
    if (load_o)      phase_d = PH_SWAP;
    else if (swap_o) phase_d = PH_LOAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_LOAD;
    else        phase_q <= phase_d;
  end

  // R2: a swap phase always hands back to the load phase
  a_r2_swap_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    swap_o |=> in_ready);
  // R2: an accepted sample is always followed by a swap phase
  a_r2_load_then_swap: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !in_ready);
  // R3: an unused load phase keeps waiting
  a_r3_idle_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready);
endmodule

// File: rtl/up2_slot_perm.sv
module up2_slot_perm #(
  parameter int W     = 8,
  parameter int NPAIR = 4,
  localparam int NS   = 2 * NPAIR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          swap_i,
  input  logic [W-1:0]  din_i,
  output logic [NS*W-1:0] slots_o,
  output logic [NS*W-1:0] slots_nxt_o
);
  logic [NS-1:0][W-1:0] cur, nxt;

  for (genvar j = 0; j < NS; j++) begin : g_slot
    logic [W-1:0] a_src, b_src;
    // load phase: new sample at the head, inner neighbours exchange, tail holds
    if (j == 0) begin : g_a_head
      assign a_src = din_i;
    end else if (j == NS - 1) begin : g_a_tail
      assign a_src = cur[j];
    end else if (j % 2 == 1) begin : g_a_up
      assign a_src = cur[j+1];
    end else begin : g_a_dn
      assign a_src = cur[j-1];
    end
    // swap phase: outer neighbours exchange
    if (j % 2 == 0) begin : g_b_up
      assign b_src = cur[j+1];
    end else begin : g_b_dn
      assign b_src = cur[j-1];
    end
    assign nxt[j] = load_i ? a_src : (swap_i ? b_src : cur[j]);
    assign slots_o[j*W +: W]     = cur[j];
    assign slots_nxt_o[j*W +: W] = nxt[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end

  // R4: the accepted sample lands in slot 1 and the last slot keeps its value
  a_r4_head_takes_input: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cur[0] == $past(din_i)) && (cur[NS-1] == $past(cur[NS-1])));
  // R5: the first pair exchanges in the swap phase
  a_r5_head_pair_swaps: assert property (@(posedge clk) disable iff (!rst_n)
    swap_i |=> (cur[0] == $past(cur[1])) && (cur[1] == $past(cur[0])));
  // R3: without an advance the store holds
  a_r3_store_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !swap_i) |=> $stable(cur));
  // R2: the two advance kinds never coincide
  a_r2_exclusive_advance: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_i && swap_i));
endmodule

// File: rtl/up2_dot.sv
module up2_dot #(
  parameter int W     = 8,
  parameter int CW    = 8,
  parameter int NPAIR = 4,
  parameter logic [NPAIR*CW-1:0] COEFS = '0,
  localparam int NS = 2 * NPAIR,
  localparam int PW = W + CW,
  localparam int OW = PW + $clog2(NPAIR)
) (
  input  logic [NS*W-1:0]        slots_i,
  output logic signed [OW-1:0]   sum_o
);
  logic [NPAIR-1:0][PW-1:0] prod;

  for (genvar k = 0; k < NPAIR; k++) begin : g_mul
    logic signed [W-1:0]  sv;
    logic signed [CW-1:0] cv;
    logic signed [PW-1:0] pv;
    assign sv = slots_i[(2*k)*W +: W];
    assign cv = COEFS[k*CW +: CW];
    assign pv = sv * cv;
    assign prod[k] = pv;
  end

  always_comb begin
    sum_o = '0;
    for (int k = 0; k < NPAIR; k++) begin
      sum_o = sum_o + OW'($signed(prod[k]));
    end
  end
endmodule

// File: rtl/up2_interp_fir.sv
module up2_interp_fir #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int NPAIR  = 4,
  parameter logic [NPAIR*COEF_W-1:0] COEFS = 32'h64_11_FB_03,
  localparam int NSLOT = 2 * NPAIR,
  localparam int OUT_W = DATA_W + COEF_W + $clog2(NPAIR)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [DATA_W-1:0]        in_data,
  output logic [NSLOT*DATA_W-1:0]  tap_slots,
  output logic                     out_valid,
  output logic [OUT_W-1:0]         out_data
);
  logic load, swap;
  logic [NSLOT*DATA_W-1:0] slots_nxt;
  logic signed [OUT_W-1:0] dot_nxt;

  up2_phase_ctrl i_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .load_o   (load),
    .swap_o   (swap)
  );

  up2_slot_perm #(.W(DATA_W), .NPAIR(NPAIR)) i_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .swap_i      (swap),
    .din_i       (in_data),
    .slots_o     (tap_slots),
    .slots_nxt_o (slots_nxt)
  );

  up2_dot #(.W(DATA_W), .CW(COEF_W), .NPAIR(NPAIR), .COEFS(COEFS)) i_dot (
    .slots_i (slots_nxt),
    .sum_o   (dot_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= load || swap;
      if (load || swap) out_data <= dot_nxt;
    end
  end

  // R6: every advance yields an output beat on the next clock
  a_r6_beat_per_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid || !in_ready) |=> out_valid);
  // R3: a stalled load phase gives no beat and keeps the last result
  a_r3_no_beat_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> (!out_valid && $stable(out_data)));
endmodule

// File: tb/test_up2_interp_fir.sv
module test_up2_interp_fir;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int NP = 4;
  localparam int NS = 2 * NP;
  localparam int OW = W + 8 + 2;
  localparam logic [31:0] COEFS = 32'h64_11_FB_03;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_data = '0;
  logic [NS*W-1:0] tap_slots;
  logic out_valid;
  logic [OW-1:0] out_data;

  int nchk = 0;
  int nfail = 0;
  int hist [0:8191];
  int n = 0;
  bit ph = 1'b0;
  bit exp_ov = 1'b0;
  int exp_out = 0;
  int coef [NP] = '{3, -5, 17, 100};

  always #(CLK_PERIOD/2) clk = ~clk;

  up2_interp_fir #(.DATA_W(W), .COEF_W(8), .NPAIR(NP), .COEFS(COEFS)) i_up2_interp_fir (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .tap_slots(tap_slots), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic int samp(int i);
    return (i <= 0) ? 0 : hist[i];
  endfunction

  // expected content of 1-based slot j from the R4/R5 orderings
  function automatic int exp_slot(int j);
    int k = (j + 1) / 2;
    bit odd = (j % 2) == 1;
    if (ph) return odd ? samp(n - (k - 1)) : samp(n - (NS - 1) + (k - 1));
    else    return odd ? samp(n - (NS - 1) + (k - 1)) : samp(n - (k - 1));
  endfunction

  function automatic int exp_dot();
    int s = 0;
    for (int k = 0; k < NP; k++) s += coef[k] * exp_slot(2 * k + 1);
    return s;
  endfunction

  task automatic check(string tag, int act, int expv);
    nchk++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic check_slots(string tag);
    for (int j = 1; j <= NS; j++) begin
      int a = int'($signed(tap_slots[(j-1)*W +: W]));
      check(tag, a, exp_slot(j));
    end
  endtask

  // drive at the falling edge, predict, then check at the next falling edge
  task automatic step(bit v, int d, string otag);
    string kind;
    in_valid = v;
    in_data  = d[W-1:0];
    if (!ph && v) begin
      n++; hist[n] = d; ph = 1'b1; exp_ov = 1'b1; kind = "R4";
    end else if (ph) begin
      ph = 1'b0; exp_ov = 1'b1; kind = v ? "R7" : "R5";
    end else begin
      exp_ov = 1'b0; kind = "R3";
    end
    if (exp_ov) exp_out = exp_dot();
    @(posedge clk);
    @(negedge clk);
    check("R2", int'(in_ready), int'(!ph));
    check(exp_ov ? "R6" : "R3", int'(out_valid), int'(exp_ov));
    check(exp_ov ? otag : "R3", int'($signed(out_data)), exp_out);
    check_slots(kind);
  endtask

  initial begin
    int seed;
    int cnt;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 8192; i++) hist[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(in_ready), 1);
    check("R1", int'(out_valid), 0);
    check("R1", int'($signed(out_data)), 0);
    check_slots("R1");
    rst_n = 1'b1;
    @(negedge clk);
    // directed ascending stream 1..10
    for (int i = 1; i <= 10; i++) begin
      step(1'b1, i, "R6");
      step(1'b1, 99, "R6");
    end
    // directed stall then offer during swap phase (R3, R7)
    step(1'b0, 55, "R6");
    step(1'b0, 66, "R6");
    step(1'b1, -7, "R6");
    step(1'b1, 77, "R6");
    // constrained random traffic
    for (int i = 0; i < 1500; i++) begin
      bit v = ($urandom_range(0, 9) < 7);
      int d = int'($urandom_range(0, 255)) - 128;
      step(v, d, "R6");
    end
    // R8: unbroken stream gives an output on every clock
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      step(1'b1, int'($urandom_range(0, 255)) - 128, "R6");
      if (out_valid) cnt++;
    end
    check("R8", cnt, 40);
    // R9: signed extremes
    for (int i = 0; i < 2 * NS; i++) step(1'b1, -128, "R9");
    check("R9", int'($signed(out_data)), -128 * (3 - 5 + 17 + 100));
    for (int i = 0; i < 2 * NS; i++) step(1'b1, 127, "R9");
    for (int i = 0; i < NS; i++) begin
      step(1'b1, (i % 2 == 0) ? -128 : 127, "R9");
      step(1'b0, 0, "R9");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule